// File: doc/BRIEF.md
# I2C Target Register File

This block is the serial front end of a small sensor-style peripheral. It listens on a two-wire I2C bus as a target at a fixed 7-bit address. Through it a host reaches a sparse bank of 8-bit registers:

- two control registers,
- a read-only 16-bit result split across two bytes,
- a 16-bit low limit and a 16-bit high limit,
- an identification byte that carries a brownout flag.

Writes send the register number and then one or more data bytes. Reads first set the register number, then issue a repeated START with the read bit set. A register pointer advances after every byte. It skips the unused gap and wraps from the identification byte back to register 0x00.

Both bus lines are synchronised and then passed through a glitch filter before any edge is decoded. SDA is driven open-drain, shown here as an output-enable that pulls the line low. The control fields, the limits, the interrupt status and the brownout flag are also presented as parallel outputs. A one-cycle strobe marks the clearing of the interrupt status, which happens when register 0x00 is read.

Top module: `i2c_rf_target`

## Requirements
- R1: Only an address byte whose upper seven bits (MSB first) equal 1000100 is acknowledged; bit 0 of that byte selects read (1) or write (0). Any other address gets no ACK and leaves every register unchanged.
- R2: The target pulls SDA low in the ninth clock after a matching address byte, after the register byte, and after every written data byte. Its SDA drive changes only while the filtered SCL is low.
- R3: The register pointer advances by one after each byte written or read, in the order 0x00..0x07, then 0x0F, then back to 0x00. Unused addresses 0x08..0x0E step to the next address.
- R4: A read is a register-byte write, a repeated START, and an address byte with bit 0 = 1. Data goes out MSB first. A host ACK fetches the next register; a host NACK ends the transfer.
- R5: A STOP that arrives before a data byte and its ACK are complete ends the transaction without changing any register.
- R6: The register layout and reset values are as follows:
  - 0x00: bits 7:5 operating mode, bit 2 interrupt status, bits 1:0 persistence.
  - 0x01: bits 3:2 resolution, bits 1:0 range.
  - 0x02/0x03: result bits 7:0 and 15:8.
  - 0x04/0x05: low limit LSB and MSB.
  - 0x06/0x07: high limit LSB and MSB.
  - Reset values are 0x00, except the high limit, which is 0xFFFF.
- R7: Register 0x0F reads {brownout, 0, 101, 000}, which is 0xA8 after reset. Its brownout bit is set by reset. Writing 0 to that bit clears it; writing 1 has no effect.
- R8: irq_set_i sets the interrupt status. The status is cleared, together with a one-cycle irq_clr_o pulse, when the transfer of a byte read from register 0x00 ends. Reads of other registers do not clear it.
- R9: Writes to the result bytes or to unused addresses are acknowledged but discarded. Unused addresses read 0x00, and the result bytes read result_i.
- R10: Pulses on SCL or SDA shorter than GLITCH_CLKS system clocks (default 5) have no effect on decoding.
- R11: Written control fields and limits appear on the parallel outputs once the data byte's ACK clock ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| result_i | input | 16 | Conversion result exposed at 0x02/0x03 |
| irq_set_i | input | 1 | Sets the interrupt status |
| op_mode_o | output | 3 | Operating mode field |
| persist_o | output | 2 | Persistence field |
| adc_res_o | output | 2 | Resolution field |
| range_o | output | 2 | Range field |
| thr_lo_o | output | 16 | Low limit |
| thr_hi_o | output | 16 | High limit |
| irq_status_o | output | 1 | Interrupt status |
| irq_clr_o | output | 1 | One-cycle pulse when the status is cleared by a read |
| brownout_o | output | 1 | Brownout flag |

## Verification
The hardest case to reach from the pins is pointer wrap-around with side effects in the same burst. Here a single write crosses 0x07, lands on 0x0F, and continues into 0x00. The stimulus starts a burst write at 0x07 so that the high limit, the brownout flag and the mode field are all hit by consecutive bytes of one transaction. A burst read from 0x00 over all nine mapped registers then checks the read order. Glitch rejection is reached by injecting short SCL and SDA pulses inside a data bit: unfiltered, these would add a clock edge or forge a START. The check is that the intended byte still lands.

// File: rtl/i2c_rf_pkg.sv
package i2c_rf_pkg;
  localparam logic [6:0] DEV_ID   = 7'b1000100;
  localparam logic [7:0] REG_LAST = 8'h0F;
  localparam logic [7:0] REG_GAP  = 8'h07;

  typedef enum logic [3:0] {
    L_IDLE, L_ADDR, L_AACK, L_REG, L_RACK, L_WDAT, L_WACK, L_RDAT, L_HACK
  } link_st_t;

  // pointer order: 0x00..0x07, 0x0F, then back to 0x00
  function automatic logic [7:0] ptr_next(input logic [7:0] p);
    if (p == REG_GAP)        return REG_LAST;
    else if (p >= REG_LAST)  return 8'h00;
    else                     return p + 8'd1;
  endfunction

  function automatic logic [7:0] id_byte(input logic bout);
    return {bout, 1'b0, 3'b101, 3'b000};
  endfunction
endpackage

// File: rtl/i2c_rf_deglitch.sv
module i2c_rf_deglitch #(
  parameter int GLITCH_CLKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(GLITCH_CLKS + 1);

  logic s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; line_o <= 1'b1; cnt <= '0;
    end else begin
      s1 <= line_i;
      s2 <= s1;
      if (s2 == line_o) cnt <= '0;
      else if (cnt == CW'(GLITCH_CLKS - 1)) begin
        line_o <= s2;
        cnt    <= '0;
      end else cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/i2c_rf_link.sv
module i2c_rf_link import i2c_rf_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic [7:0] rd_byte,
  output logic       sda_oe,
  output logic [7:0] ptr,
  output logic       wr_en,
  output logic [7:0] wr_data,
  output logic       rd_done,
  output logic       start_ev,
  output logic       stop_ev
);
  link_st_t   st;
  logic       scl_q, sda_q, hack, rw;
  logic [7:0] sh;
  logic [3:0] cnt;
  logic       rise, fall;

  assign rise     = scl_f & ~scl_q;
  assign fall     = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
  assign wr_en    = (st == L_WACK) & fall;
  assign wr_data  = sh;
  assign rd_done  = (st == L_RDAT) & fall & (cnt == 4'd7);
  assign sda_oe   = (st == L_AACK) | (st == L_RACK) | (st == L_WACK) |
                    ((st == L_RDAT) & ~sh[7]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= L_IDLE; scl_q <= 1'b1; sda_q <= 1'b1;
      sh <= '0; cnt <= '0; hack <= 1'b0; rw <= 1'b0; ptr <= '0;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
      if (start_ev) begin
        st  <= L_ADDR;
        cnt <= '0;
      end else if (stop_ev) begin
        st <= L_IDLE;
      end else begin
        case (st)
          L_ADDR, L_REG, L_WDAT: begin
            if (rise) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 4'd1;
            end else if (fall && cnt == 4'd8) begin
              cnt <= '0;
              if (st == L_ADDR) begin
                if (sh[7:1] == DEV_ID) begin rw <= sh[0]; st <= L_AACK; end
                else st <= L_IDLE;
              end else if (st == L_REG) begin
                ptr <= sh;
                st  <= L_RACK;
              end else st <= L_WACK;
            end
          end
          L_AACK: if (fall) begin
            if (rw) begin st <= L_RDAT; sh <= rd_byte; end
            else st <= L_REG;
          end
          L_RACK: if (fall) st <= L_WDAT;
          L_WACK: if (fall) begin
            ptr <= ptr_next(ptr);
            st  <= L_WDAT;
          end
          L_RDAT: if (fall) begin
            sh  <= {sh[6:0], 1'b0};
            cnt <= cnt + 4'd1;
            if (cnt == 4'd7) begin
              cnt <= '0;
              ptr <= ptr_next(ptr);
              st  <= L_HACK;
            end
          end
          L_HACK: begin
            if (rise) hack <= ~sda_f;
            else if (fall) begin
              if (hack) begin st <= L_RDAT; sh <= rd_byte; end
              else st <= L_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_rf_regbank.sv
module i2c_rf_regbank import i2c_rf_pkg::*; (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic [7:0]  rd_addr,
  output logic [7:0]  rd_byte,
  input  logic [15:0] result_i,
  input  logic        irq_set_i,
  input  logic        irq_clr,
  output logic [2:0]  op_mode,
  output logic [1:0]  persist,
  output logic [1:0]  adc_res,
  output logic [1:0]  range_sel,
  output logic [15:0] thr_lo,
  output logic [15:0] thr_hi,
  output logic        irq_st,
  output logic        bout
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_mode <= '0; persist <= '0; adc_res <= '0; range_sel <= '0;
      thr_lo <= 16'h0000; thr_hi <= 16'hFFFF; irq_st <= 1'b0; bout <= 1'b1;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          8'h00: begin op_mode <= wr_data[7:5]; persist <= wr_data[1:0]; end
          8'h01: begin adc_res <= wr_data[3:2]; range_sel <= wr_data[1:0]; end
          8'h04: thr_lo[7:0]  <= wr_data;
          8'h05: thr_lo[15:8] <= wr_data;
          8'h06: thr_hi[7:0]  <= wr_data;
          8'h07: thr_hi[15:8] <= wr_data;
          REG_LAST: if (!wr_data[7]) bout <= 1'b0;
          default: ;
        endcase
      end
      if (irq_set_i) irq_st <= 1'b1;
      else if (irq_clr) irq_st <= 1'b0;
    end
  end

  always_comb begin
    case (rd_addr)
      8'h00:    rd_byte = {op_mode, 2'b00, irq_st, persist};
      8'h01:    rd_byte = {4'b0000, adc_res, range_sel};
      8'h02:    rd_byte = result_i[7:0];
      8'h03:    rd_byte = result_i[15:8];
      8'h04:    rd_byte = thr_lo[7:0];
      8'h05:    rd_byte = thr_lo[15:8];
      8'h06:    rd_byte = thr_hi[7:0];
      8'h07:    rd_byte = thr_hi[15:8];
      REG_LAST: rd_byte = id_byte(bout);
      default:  rd_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/i2c_rf_target.sv
module i2c_rf_target import i2c_rf_pkg::*; #(
  parameter int GLITCH_CLKS = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  input  logic [15:0] result_i,
  input  logic        irq_set_i,
  output logic [2:0]  op_mode_o,
  output logic [1:0]  persist_o,
  output logic [1:0]  adc_res_o,
  output logic [1:0]  range_o,
  output logic [15:0] thr_lo_o,
  output logic [15:0] thr_hi_o,
  output logic        irq_status_o,
  output logic        irq_clr_o,
  output logic        brownout_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, filt;
  logic       scl_f, sda_f;
  logic [7:0] ptr, wr_data, rd_byte;
  logic       wr_en, rd_done, start_ev, stop_ev;

  assign raw   = {sda_i, scl_i};
  assign scl_f = filt[0];
  assign sda_f = filt[1];

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    i2c_rf_deglitch #(.GLITCH_CLKS(GLITCH_CLKS)) u_flt (
      .clk(clk), .rst_n(rst_n), .line_i(raw[i]), .line_o(filt[i]));
  end

  i2c_rf_link u_link (
    .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f), .rd_byte(rd_byte),
    .sda_oe(sda_oe_o), .ptr(ptr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_done(rd_done), .start_ev(start_ev), .stop_ev(stop_ev));

  assign irq_clr_o = rd_done & (ptr == 8'h00);

  i2c_rf_regbank u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(ptr), .wr_data(wr_data),
    .rd_addr(ptr), .rd_byte(rd_byte), .result_i(result_i),
    .irq_set_i(irq_set_i), .irq_clr(irq_clr_o),
    .op_mode(op_mode_o), .persist(persist_o), .adc_res(adc_res_o),
    .range_sel(range_o), .thr_lo(thr_lo_o), .thr_hi(thr_hi_o),
    .irq_st(irq_status_o), .bout(brownout_o));
endmodule

// File: rtl/i2c_rf_chk.sv
module i2c_rf_chk import i2c_rf_pkg::*; (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       sda_oe,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       wr_en,
  input logic [7:0] ptr,
  input logic       irq_clr,
  input logic       irq_set,
  input logic       irq_st,
  input logic       bout
);
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_f); // R2

  AST_START_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !sda_oe); // R1

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_oe); // R5

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ptr == ptr_next($past(ptr)))); // R3

  AST_IRQ_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_set) |=> !irq_st); // R8

  AST_BOUT_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(bout)); // R7
endmodule

bind i2c_rf_target i2c_rf_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_oe(sda_oe_o),
  .start_ev(start_ev), .stop_ev(stop_ev), .wr_en(wr_en), .ptr(ptr),
  .irq_clr(irq_clr_o), .irq_set(irq_set_i), .irq_st(irq_status_o),
  .bout(brownout_o));

// File: tb/sim_i2c_rf_target.sv
module sim_i2c_rf_target;
  localparam int Q = 25;
  localparam logic [7:0] AW = 8'h88;
  localparam logic [7:0] AR = 8'h89;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1, irq_set = 1'b0;
  logic [15:0] result = 16'hBEEF;
  logic sda_oe, irq_clr, irq_st, bout;
  logic [2:0] op_mode;
  logic [1:0] persist, adc_res, range_sel;
  logic [15:0] thr_lo, thr_hi;
  logic sda_line;
  int nchk = 0, nfail = 0, nclr = 0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [10];

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_rf_target u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .result_i(result), .irq_set_i(irq_set), .op_mode_o(op_mode),
    .persist_o(persist), .adc_res_o(adc_res), .range_o(range_sel),
    .thr_lo_o(thr_lo), .thr_hi_o(thr_hi), .irq_status_o(irq_st),
    .irq_clr_o(irq_clr), .brownout_o(bout));

  always @(posedge clk) if (irq_clr) nclr++;

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    if (!scl) begin sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); end
    sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(2*Q);
  endtask

  task automatic send_bit(input logic b, input logic glitch);
    sda_m = b;
    if (glitch) begin wt(8); scl = 1'b1; wt(3); scl = 1'b0; wt(Q-11); end
    else wt(Q);
    scl = 1'b1;
    if (glitch) begin wt(Q); sda_m = ~b; wt(3); sda_m = b; wt(Q-3); end
    else wt(2*Q);
    scl = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input int g, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i], (7 - i) == g);
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q);
    ack = ~sda_line;
    wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(2*Q); scl = 1'b1; wt(Q); b[i] = sda_line; wt(Q); scl = 1'b0;
    end
    wt(Q); sda_m = ~give_ack; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
    sda_m = 1'b1;
  endtask

  task automatic wr_regs(input logic [7:0] ra, input int n, input int g);
    logic ack;
    bus_start();
    send_byte(AW, 8, ack);  check("R2 addr ack", 32'(ack), 1);
    send_byte(ra, 8, ack);  check("R2 reg ack", 32'(ack), 1);
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], (i == 0) ? g : 8, ack);
      check("R2 data ack", 32'(ack), 1);
    end
    bus_stop();
  endtask

  task automatic rd_regs(input logic [7:0] ra, input int n);
    logic ack;
    bus_start();
    send_byte(AW, 8, ack);
    send_byte(ra, 8, ack);
    bus_start();
    send_byte(AR, 8, ack);  check("R4 read addr ack", 32'(ack), 1);
    for (int i = 0; i < n; i++) recv_byte(i < n - 1, rbuf[i]);
    bus_stop();
  endtask

  task automatic t_reset();
    check("R6 op_mode reset", 32'(op_mode), 0);
    check("R6 persist reset", 32'(persist), 0);
    check("R6 thr_lo reset", 32'(thr_lo), 32'h0000);
    check("R6 thr_hi reset", 32'(thr_hi), 32'hFFFF);
    check("R7 brownout reset", 32'(bout), 1);
    check("R8 irq reset", 32'(irq_st), 0);
    check("R2 sda released", 32'(sda_oe), 0);
  endtask

  task automatic t_wrong_addr();
    logic ack;
    bus_start();
    send_byte(8'h8A, 8, ack);
    check("R1 foreign address nack", 32'(ack), 0);
    send_byte(8'hE0, 8, ack);
    check("R1 no ack after foreign address", 32'(ack), 0);
    bus_stop();
    check("R1 mode untouched", 32'(op_mode), 0);
  endtask

  task automatic t_id_read();
    rd_regs(8'h0F, 1);
    check("R7 id byte after reset", 32'(rbuf[0]), 32'hA8);
  endtask

  task automatic t_burst();
    wbuf = '{8'hA3, 8'h0E, 8'h55, 8'h66, 8'h12, 8'h34, 8'h56, 8'h78};
    wr_regs(8'h00, 8, 8);
    check("R11 op_mode", 32'(op_mode), 5);
    check("R11 persist", 32'(persist), 3);
    check("R11 adc_res", 32'(adc_res), 3);
    check("R11 range", 32'(range_sel), 2);
    check("R9 R11 thr_lo", 32'(thr_lo), 32'h3412);
    check("R11 thr_hi", 32'(thr_hi), 32'h7856);
    rd_regs(8'h00, 9);
    check("R4 r0", 32'(rbuf[0]), 32'hA3);
    check("R4 r1", 32'(rbuf[1]), 32'h0E);
    check("R9 result lo", 32'(rbuf[2]), 32'hEF);
    check("R9 result hi", 32'(rbuf[3]), 32'hBE);
    check("R3 r4", 32'(rbuf[4]), 32'h12);
    check("R3 r5", 32'(rbuf[5]), 32'h34);
    check("R3 r6", 32'(rbuf[6]), 32'h56);
    check("R3 r7", 32'(rbuf[7]), 32'h78);
    check("R3 gap skipped to id", 32'(rbuf[8]), 32'hA8);
  endtask

  task automatic t_wrap();
    wbuf[0] = 8'h9A; wbuf[1] = 8'h00; wbuf[2] = 8'h41;
    wr_regs(8'h07, 3, 8);
    check("R3 wrap thr_hi", 32'(thr_hi), 32'h9A56);
    check("R7 brownout cleared", 32'(bout), 0);
    check("R3 wrap to r0 op", 32'(op_mode), 2);
    check("R3 wrap to r0 persist", 32'(persist), 1);
    wbuf[0] = 8'h80;
    wr_regs(8'h0F, 1, 8);
    check("R7 write 1 ignored", 32'(bout), 0);
    rd_regs(8'h0F, 1);
    check("R7 id after clear", 32'(rbuf[0]), 32'h28);
  endtask

  task automatic t_unmapped();
    wbuf[0] = 8'h77; wr_regs(8'h09, 1, 8);
    wbuf[0] = 8'h11; wr_regs(8'h02, 1, 8);
    rd_regs(8'h0E, 2);
    check("R9 unmapped reads zero", 32'(rbuf[0]), 32'h00);
    check("R3 unmapped steps to id", 32'(rbuf[1]), 32'h28);
    rd_regs(8'h02, 1);
    check("R9 result write discarded", 32'(rbuf[0]), 32'hEF);
    rd_regs(8'h09, 1);
    check("R9 unmapped write discarded", 32'(rbuf[0]), 32'h00);
  endtask

  task automatic t_abort();
    logic ack;
    bus_start();
    send_byte(AW, 8, ack);
    send_byte(8'h04, 8, ack);
    for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
    bus_stop();
    check("R5 aborted byte not written", 32'(thr_lo), 32'h3412);
    rd_regs(8'h04, 1);
    check("R5 readback after abort", 32'(rbuf[0]), 32'h12);
  endtask

  task automatic t_irq();
    irq_set = 1'b1; wt(1); irq_set = 1'b0; wt(2);
    check("R8 status set", 32'(irq_st), 1);
    nclr = 0;
    rd_regs(8'h01, 1);
    check("R8 other read keeps status", 32'(irq_st), 1);
    check("R8 no clear pulse", 32'(nclr), 0);
    rd_regs(8'h00, 1);
    check("R8 r0 shows status", 32'(rbuf[0]), 32'h45);
    check("R8 status cleared", 32'(irq_st), 0);
    check("R8 one clear pulse", 32'(nclr), 1);
  endtask

  task automatic t_glitch();
    wbuf[0] = 8'h5A;
    wr_regs(8'h05, 1, 3);
    check("R10 glitched byte intact", 32'(thr_lo), 32'h5A12);
  endtask

  initial begin
    wt(4); rst_n = 1'b1; wt(4);
    t_reset();
    t_wrong_addr();
    t_id_read();
    t_burst();
    t_wrap();
    t_unmapped();
    t_abort();
    t_irq();
    t_glitch();
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule